// File: doc/BRIEF.md
# Guarded 128-bit Packed XOR Unit

This block performs a 128-bit bitwise exclusive-OR of a destination register value with a source operand. The source is either a second register value or a value already fetched from memory. Before the result is written back, the block checks every condition that must stop the instruction. These include control-bit state, feature availability, a lock prefix, operand alignment, address-range rules that depend on the processor mode, and segment and page faults reported from outside the block. At most one fault is reported, and it is the one with the highest priority. The XOR result commits only when no fault applies.

The caller presents one instruction per cycle, with `in_valid` high. One clock later the registered outputs carry the outcome. Either `wr_en` is high with the new `result`, or `fault_vec` has exactly one bit set and `result` keeps its previous committed value. Memory access, paging and the register file are outside the block. Page and segment faults reach it as plain flags. The unit never raises a floating-point exception.

Top module: `simd_xor_guard`

## Requirements
- R1: One cycle after a valid instruction with no fault, `wr_en` is 1 and `result` equals the destination XOR the selected source, over all 128 bits.
- R2: `use_mem`=1 selects `src_mem` as the source; `use_mem`=0 selects `src_reg`, and in that case the address and every memory-related fault input are ignored.
- R3: Fault code 5'b00001 (invalid opcode, bit 0) is raised when `ctl_emul`=1, `ctl_os_xstate`=0, `feat_simd`=0 or `lock_pfx`=1. It outranks every other fault.
- R4: Fault code 5'b00010 (device unavailable, bit 1) is raised when `ctl_task_sw`=1 and R3 does not apply.
- R5: With a memory operand, an address whose low 4 bits are not all zero raises fault code 5'b00100 (general protection, bit 2), in every mode.
- R6: Mode encoding: 0 real, 1 virtual-8086, 2 protected or compatibility, 3 64-bit. In modes 0 and 1, a memory address above 0xFFF0 (the 16-byte operand runs past 0xFFFF) raises general protection.
- R7: In mode 3, an address whose bits 63..47 are not all equal raises general protection. When `stack_seg`=1 it raises fault code 5'b01000 (stack, bit 3) instead.
- R8: In mode 2, `seg_bad`=1 raises general protection, or stack when `stack_seg`=1. `seg_bad` is ignored in modes 0, 1 and 3.
- R9: `page_fault`=1 raises fault code 5'b10000 (page, bit 4) with a memory operand in modes 1, 2 and 3. It is ignored in mode 0, and it has the lowest priority.
- R10: `fault_vec` is one-hot or zero. When general protection and stack both apply, general protection wins. Any fault holds `wr_en` at 0 and leaves `result` unchanged.
- R11: In a cycle after `in_valid`=0, `wr_en` and `fault_vec` are 0, whatever the other inputs are.
- R12: Synchronous reset clears `result`, `wr_en` and `fault_vec` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented this cycle |
| dst_val | input | 128 | Current destination register value |
| src_reg | input | 128 | Register source operand |
| src_mem | input | 128 | Memory source operand, already fetched |
| use_mem | input | 1 | Source is memory |
| mem_addr | input | 64 | Effective address of the memory operand |
| cpu_mode | input | 2 | Processor mode (0 real, 1 virtual-8086, 2 protected/compat, 3 64-bit) |
| ctl_emul | input | 1 | Emulation control bit |
| ctl_task_sw | input | 1 | Task-switched control bit |
| ctl_os_xstate | input | 1 | OS extended-state support control bit |
| feat_simd | input | 1 | SIMD feature present |
| lock_pfx | input | 1 | Lock prefix present |
| stack_seg | input | 1 | Memory operand uses the stack segment |
| seg_bad | input | 1 | Segment check reports an illegal address |
| page_fault | input | 1 | Translation reports a page fault |
| result | output | 128 | Last committed XOR result |
| wr_en | output | 1 | Destination write enable |
| fault_vec | output | 5 | One-hot fault: bit0 opcode, bit1 device, bit2 protection, bit3 stack, bit4 page |

## Verification
The hardest situations to reach are those where several faults apply at once and only the priority order decides which one is reported. Examples are a lock prefix together with a set task-switch bit, a misaligned stack-segment address with a segment violation, and page or segment flags raised in a mode that must ignore them. The vector table builds each of these overlaps on purpose. Each faulting entry is followed by a check that `result` still holds the last committed value. Directed steps then drive `in_valid` low while fault inputs are set, and apply reset in the middle of a run.

// File: rtl/sxg_pkg.sv
package sxg_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } cpu_mode_e;

  localparam int FAULT_N = 5;
  localparam int F_UD = 0;
  localparam int F_NM = 1;
  localparam int F_GP = 2;
  localparam int F_SS = 3;
  localparam int F_PF = 4;
endpackage

// File: rtl/sxg_xor_lanes.sv
module sxg_xor_lanes #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 32
) (
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_reg,
  input  logic [DATA_W-1:0] src_mem,
  input  logic              use_mem,
  output logic [DATA_W-1:0] xor_out
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] opnd;
    assign opnd = use_mem ? src_mem[l*LANE_W +: LANE_W] : src_reg[l*LANE_W +: LANE_W];
    assign xor_out[l*LANE_W +: LANE_W] = dst_val[l*LANE_W +: LANE_W] ^ opnd;
  end
endmodule

// File: rtl/sxg_addr_check.sv
module sxg_addr_check #(
  parameter int          ADDR_W      = 64,
  parameter int          VA_BITS     = 48,
  parameter int          ALIGN_BYTES = 16,
  parameter int unsigned REAL_LIMIT  = 32'h0000_FFFF
) (
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              misaligned,
  output logic              real_over,
  output logic              noncanon
);
  localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);
  localparam logic [ADDR_W-1:0] LAST_START =
    ADDR_W'(REAL_LIMIT) - ADDR_W'(ALIGN_BYTES) + ADDR_W'(1);
  localparam int HI_W = ADDR_W - VA_BITS + 1;

  logic [HI_W-1:0] upper;

  assign upper      = mem_addr[ADDR_W-1:VA_BITS-1];
  assign misaligned = |mem_addr[ALIGN_LSB-1:0];
  assign real_over  = mem_addr > LAST_START;
  assign noncanon   = !((&upper) || (~|upper));
endmodule

// File: rtl/sxg_fault_eval.sv
module sxg_fault_eval
  import sxg_pkg::*;
(
  input  logic [1:0]         cpu_mode,
  input  logic               ctl_emul,
  input  logic               ctl_task_sw,
  input  logic               ctl_os_xstate,
  input  logic               feat_simd,
  input  logic               lock_pfx,
  input  logic               use_mem,
  input  logic               stack_seg,
  input  logic               seg_bad,
  input  logic               page_fault,
  input  logic               misaligned,
  input  logic               real_over,
  input  logic               noncanon,
  output logic [FAULT_N-1:0] fault
);
  cpu_mode_e mode;
  logic ud, nm, gp, ss, pf, seg_mode, small_mode;

  assign mode       = cpu_mode_e'(cpu_mode);
  assign small_mode = (mode == MODE_REAL) || (mode == MODE_V86);
  assign seg_mode   = (mode == MODE_PROT);

  assign ud = ctl_emul || !ctl_os_xstate || !feat_simd || lock_pfx;
  assign nm = ctl_task_sw;
  assign gp = use_mem && (misaligned
                          || (small_mode && real_over)
                          || ((mode == MODE_LONG) && noncanon && !stack_seg)
                          || (seg_mode && seg_bad && !stack_seg));
  assign ss = use_mem && (((mode == MODE_LONG) && noncanon && stack_seg)
                          || (seg_mode && seg_bad && stack_seg));
  assign pf = use_mem && page_fault && (mode != MODE_REAL);

  always_comb begin
    fault = '0;
    if (ud)      fault[F_UD] = 1'b1;
    else if (nm) fault[F_NM] = 1'b1;
    else if (gp) fault[F_GP] = 1'b1;
    else if (ss) fault[F_SS] = 1'b1;
    else if (pf) fault[F_PF] = 1'b1;
  end
endmodule

// File: rtl/simd_xor_guard.sv
module simd_xor_guard
  import sxg_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int LANE_W  = 32,
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_reg,
  input  logic [DATA_W-1:0] src_mem,
  input  logic              use_mem,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [1:0]        cpu_mode,
  input  logic              ctl_emul,
  input  logic              ctl_task_sw,
  input  logic              ctl_os_xstate,
  input  logic              feat_simd,
  input  logic              lock_pfx,
  input  logic              stack_seg,
  input  logic              seg_bad,
  input  logic              page_fault,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [4:0]        fault_vec
);
  logic [DATA_W-1:0]  xor_out;
  logic               misaligned, real_over, noncanon;
  logic [FAULT_N-1:0] fault;
  logic               commit;

  sxg_xor_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lanes (
    .dst_val(dst_val), .src_reg(src_reg), .src_mem(src_mem),
    .use_mem(use_mem), .xor_out(xor_out)
  );

  sxg_addr_check #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_addr (
    .mem_addr(mem_addr), .misaligned(misaligned),
    .real_over(real_over), .noncanon(noncanon)
  );

  sxg_fault_eval u_fault (
    .cpu_mode(cpu_mode), .ctl_emul(ctl_emul), .ctl_task_sw(ctl_task_sw),
    .ctl_os_xstate(ctl_os_xstate), .feat_simd(feat_simd), .lock_pfx(lock_pfx),
    .use_mem(use_mem), .stack_seg(stack_seg), .seg_bad(seg_bad),
    .page_fault(page_fault), .misaligned(misaligned), .real_over(real_over),
    .noncanon(noncanon), .fault(fault)
  );

  assign commit = in_valid && (fault == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      wr_en     <= 1'b0;
      fault_vec <= '0;
    end else begin
      wr_en     <= commit;
      fault_vec <= in_valid ? fault : '0;
      if (commit) result <= xor_out;
    end
  end
endmodule

// File: rtl/sxg_checker.sv
module sxg_checker #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] dst_val,
  input logic [DATA_W-1:0] src_reg,
  input logic [DATA_W-1:0] src_mem,
  input logic              use_mem,
  input logic              ctl_emul,
  input logic              ctl_task_sw,
  input logic              ctl_os_xstate,
  input logic              feat_simd,
  input logic              lock_pfx,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic [4:0]        fault_vec
);
  p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fault_vec));

  p_no_write_on_fault_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (fault_vec == 5'b0));

  p_hold_result_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !$past(rst)) |-> $stable(result));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wr_en && fault_vec == 5'b0));

  p_lock_opcode_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lock_pfx) |=> (fault_vec == 5'b00001));

  p_task_switch_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctl_task_sw && !ctl_emul && ctl_os_xstate && feat_simd && !lock_pfx)
      |=> (fault_vec == 5'b00010));

  p_commit_value_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (result == ($past(dst_val) ^ ($past(use_mem) ? $past(src_mem) : $past(src_reg)))));
endmodule

bind simd_xor_guard sxg_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dst_val(dst_val),
  .src_reg(src_reg), .src_mem(src_mem), .use_mem(use_mem),
  .ctl_emul(ctl_emul), .ctl_task_sw(ctl_task_sw), .ctl_os_xstate(ctl_os_xstate),
  .feat_simd(feat_simd), .lock_pfx(lock_pfx), .result(result),
  .wr_en(wr_en), .fault_vec(fault_vec)
);

// File: tb/simd_xor_guard_bench.sv
`timescale 1ns/100ps
module simd_xor_guard_bench;
  typedef struct packed {
    logic [1:0]  mode;
    logic        em, ts, osx, feat, lock, mem, stk, segb, pgf;
    logic [63:0] addr;
    logic [4:0]  expf;
  } vec_t;

  localparam logic [4:0] OK = 5'b00000, UD = 5'b00001, NM = 5'b00010,
                         GP = 5'b00100, SS = 5'b01000, PF = 5'b10000;
  localparam int NV = 18;
  localparam vec_t TV [NV] = '{
    '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,64'h3,OK},                  // R1 R2 register ignores addr/faults
    '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,64'h1000,OK},               // R2 memory source
    '{2'd2,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0,UD},                  // R3 emulation
    '{2'd2,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0,UD},                  // R3 os support off
    '{2'd3,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0,UD},                  // R3 feature off
    '{2'd2,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,64'h1,UD},                  // R3 lock beats task switch
    '{2'd2,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,64'h7,NM},                  // R4 over misalign
    '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,64'h1008,GP},               // R5
    '{2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,64'h0000_8000_0000_0000,GP},// R7
    '{2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,64'h0000_8000_0000_0000,SS},// R7 stack
    '{2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,64'hFFFF_8000_0000_0010,OK},// R7 canonical
    '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,64'h1_0000,GP},             // R6 real overrun
    '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,64'hFFF0,OK},               // R6 R8 R9 real ignores
    '{2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,64'hFFF0,PF},               // R9 v86 page
    '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,64'h2000,SS},               // R8 stack over page
    '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,64'h2000,GP},               // R8
    '{2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,64'h20,OK},                 // R8 ignored in 64-bit
    '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,64'h2004,GP}                // R10 gp beats ss
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, use_mem = 1'b0;
  logic [127:0] dst_val = '0, src_reg = '0, src_mem = '0, result;
  logic [63:0] mem_addr = '0;
  logic [1:0] cpu_mode = 2'd2;
  logic ctl_emul = 0, ctl_task_sw = 0, ctl_os_xstate = 1, feat_simd = 1, lock_pfx = 0;
  logic stack_seg = 0, seg_bad = 0, page_fault = 0, wr_en;
  logic [4:0] fault_vec;
  int checks = 0, errors = 0;
  logic [127:0] last_ok = '0;

  always #2.5 clk = ~clk;

  simd_xor_guard u_simd_xor_guard (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dst_val(dst_val),
    .src_reg(src_reg), .src_mem(src_mem), .use_mem(use_mem), .mem_addr(mem_addr),
    .cpu_mode(cpu_mode), .ctl_emul(ctl_emul), .ctl_task_sw(ctl_task_sw),
    .ctl_os_xstate(ctl_os_xstate), .feat_simd(feat_simd), .lock_pfx(lock_pfx),
    .stack_seg(stack_seg), .seg_bad(seg_bad), .page_fault(page_fault),
    .result(result), .wr_en(wr_en), .fault_vec(fault_vec)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [127:0] exp_res;
    step(); step();
    // R12 reset state
    check("R12 result", result, '0);
    check("R12 wr_en", 128'(wr_en), 128'(0));
    check("R12 fault", 128'(fault_vec), 128'(0));
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      in_valid      = 1'b1;
      cpu_mode      = TV[i].mode;
      ctl_emul      = TV[i].em;
      ctl_task_sw   = TV[i].ts;
      ctl_os_xstate = TV[i].osx;
      feat_simd     = TV[i].feat;
      lock_pfx      = TV[i].lock;
      use_mem       = TV[i].mem;
      stack_seg     = TV[i].stk;
      seg_bad       = TV[i].segb;
      page_fault    = TV[i].pgf;
      mem_addr      = TV[i].addr;
      dst_val       = {96'h0123_4567_89AB_CDEF_0011_2233, 32'(i)};
      src_reg       = {4{32'hA5A5_5A5A}} ^ {32'(i * 7), 96'h0};
      src_mem       = ~src_reg ^ {96'h0, 32'hFFFF_0000};
      exp_res       = dst_val ^ (TV[i].mem ? src_mem : src_reg);
      step();
      check($sformatf("R3-R9 fault vec %0d", i), 128'(fault_vec), 128'(TV[i].expf));
      if (TV[i].expf == OK) begin
        check($sformatf("R1 R2 result vec %0d", i), result, exp_res);
        check($sformatf("R1 wr_en vec %0d", i), 128'(wr_en), 128'(1));
        last_ok = exp_res;
      end else begin
        check($sformatf("R10 held result vec %0d", i), result, last_ok);
        check($sformatf("R10 wr_en vec %0d", i), 128'(wr_en), 128'(0));
      end
    end

    // R11: invalid cycle with fault conditions present stays quiet
    in_valid = 1'b0; ctl_emul = 1'b1; page_fault = 1'b1;
    step();
    check("R11 fault idle", 128'(fault_vec), 128'(0));
    check("R11 wr_en idle", 128'(wr_en), 128'(0));
    check("R11 result idle", result, last_ok);

    // R12: reset in the middle of a run clears committed result
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R12 mid reset result", result, '0);
    check("R12 mid reset fault", 128'(fault_vec), 128'(0));

    step();
    finish_run();
  end
endmodule